// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It takes the branch's 16-bit program counter and combines three of its bits with a short global record of recent branch outcomes. The result selects one entry of a small table of saturating counters. The upper bit of the selected counter is the guess. Mixing the history into the index lets the same branch use different counters depending on how the branches before it resolved.

Lookup is purely combinational. A front end presents a PC and reads back the selected index, the raw counter and the taken flag in the same cycle. When the branch resolves, the back end presents the branch PC and its real outcome with a valid strobe. The counter and the history both change at the next clock edge. The update recomputes its index from the history as it stood before the shift, so the counter that is trained is the one that produced the guess.

Top module: `gshr_predictor`

## Requirements
- R1: The lookup index `pred_idx` equals PC bits 6..4 XOR the 3-bit global history. It is available in the same cycle as `pred_pc`.
- R2: `pred_ctr` is the counter stored at `pred_idx`. `pred_taken` is that counter's bit 1, where 1 means taken. Both follow `pred_pc` combinationally.
- R3: An update with outcome taken (`upd_taken`=1) raises the selected counter by one. A counter already at 3 stays at 3.
- R4: An update with outcome not taken lowers the selected counter by one. A counter already at 0 stays at 0.
- R5: Each update shifts the history left by one place. The outcome enters at bit 0 (1 = taken), and the old bit 2 is discarded.
- R6: An update selects its counter as `upd_pc` bits 6..4 XOR the history before that same update's shift.
- R7: After reset, every counter holds 1 (weakly not taken) and the history is 0.
- R8: While `upd_valid` is low, `upd_pc` and `upd_taken` have no effect: no counter and no history bit changes.
- R9: PC bits outside 6..4 do not affect the index. With history 0b011, PC 0x0100 selects entry 3 and PC 0x2454 selects entry 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | 16 | PC of the branch being looked up |
| pred_idx | output | 3 | Table entry selected for the lookup |
| pred_ctr | output | 2 | Counter value at that entry |
| pred_taken | output | 1 | Guess: 1 = taken |
| upd_valid | input | 1 | Apply a resolved outcome this cycle |
| upd_pc | input | 16 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome: 1 = taken |

## Verification
After reset, every PC field value is looked up. This shows that the index tracks PC bits 6..4 and that all counters start weakly not taken. Outcome runs that are all taken or all not taken at fixed PCs drive the history to all ones or all zeros and push one counter against each limit. These runs separate correct saturation from wrap-around. A pseudo-random sequence of PCs and outcomes follows, checked against a reference model. It exposes errors in history shift order and any use of the post-shift history for the update index. Strobes held low while the outcome and PC toggle confirm that nothing moves without a valid update.

// File: rtl/gshr_pkg.sv
package gshr_pkg;

   localparam int DEF_PC_W    = 16;
   localparam int DEF_IDX_LO  = 4;
   localparam int DEF_HIST_W  = 3;
   localparam int DEF_CTR_W   = 2;
   localparam int DEF_CTR_INIT = 1;

   // saturating up/down step of a counter of width w
   function automatic int unsigned sat_step(int unsigned cur, bit up, int unsigned cmax);
      if (up) return (cur >= cmax) ? cmax : cur + 1;
      else    return (cur == 0) ? 0 : cur - 1;
   endfunction

endpackage

// File: rtl/gshr_index.sv
module gshr_index #(
   parameter int PC_W   = gshr_pkg::DEF_PC_W,
   parameter int IDX_LO = gshr_pkg::DEF_IDX_LO,
   parameter int HIST_W = gshr_pkg::DEF_HIST_W
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [HIST_W-1:0] hist,
   output logic [HIST_W-1:0] idx
);
   localparam int IDX_HI = IDX_LO + HIST_W - 1;

   if (IDX_HI >= PC_W) begin : g_bad_field
      $error("gshr_index: PC field exceeds PC width");
   end

   logic [HIST_W-1:0] pc_field;

   for (genvar b = 0; b < HIST_W; b++) begin : g_bit
      assign pc_field[b] = pc[IDX_LO + b];
      assign idx[b]      = pc_field[b] ^ hist[b];
   end
endmodule

// File: rtl/gshr_history.sv
module gshr_history #(
   parameter int HIST_W = gshr_pkg::DEF_HIST_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              outcome,
   output logic [HIST_W-1:0] hist
);
   if (HIST_W < 1) begin : g_bad_width
      $error("gshr_history: history width must be at least 1");
   end

   logic [HIST_W-1:0] hist_q;

   if (HIST_W == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        hist_q <= '0;
         else if (shift_en) hist_q <= outcome;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        hist_q <= '0;
         else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], outcome};
      end
   end

   assign hist = hist_q;
endmodule

// File: rtl/gshr_ctr_table.sv
module gshr_ctr_table #(
   parameter int IDX_W    = gshr_pkg::DEF_HIST_W,
   parameter int CTR_W    = gshr_pkg::DEF_CTR_W,
   parameter int CTR_INIT = gshr_pkg::DEF_CTR_INIT
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IDX_W-1:0]            rd_idx,
   output logic [CTR_W-1:0]            rd_ctr,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic                        wr_up,
   output logic [(1<<IDX_W)*CTR_W-1:0] ctr_flat
);
   localparam int N_ENT = 1 << IDX_W;
   localparam int CMAX  = (1 << CTR_W) - 1;

   if (CTR_W < 1 || CTR_W > 8) begin : g_bad_ctr
      $error("gshr_ctr_table: counter width out of range");
   end
   if (CTR_INIT < 0 || CTR_INIT > CMAX) begin : g_bad_init
      $error("gshr_ctr_table: initial counter value out of range");
   end
   if (IDX_W > 10) begin : g_bad_depth
      $error("gshr_ctr_table: table too deep");
   end

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      logic [CTR_W-1:0] ctr_q;
      logic [CTR_W-1:0] ctr_nx;
      logic             hit;

      assign hit = wr_en && (wr_idx == IDX_W'(e));

      always_comb begin
         ctr_nx = CTR_W'(gshr_pkg::sat_step(int'(ctr_q), wr_up, CMAX));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   ctr_q <= CTR_W'(CTR_INIT);
         else if (hit) ctr_q <= ctr_nx;
      end

      assign ctr_flat[e*CTR_W +: CTR_W] = ctr_q;
   end

   assign rd_ctr = ctr_flat[rd_idx*CTR_W +: CTR_W];
endmodule

// File: rtl/gshr_predictor.sv
module gshr_predictor #(
   parameter int PC_W     = gshr_pkg::DEF_PC_W,
   parameter int IDX_LO   = gshr_pkg::DEF_IDX_LO,
   parameter int HIST_W   = gshr_pkg::DEF_HIST_W,
   parameter int CTR_W    = gshr_pkg::DEF_CTR_W,
   parameter int CTR_INIT = gshr_pkg::DEF_CTR_INIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   pred_pc,
   output logic [HIST_W-1:0] pred_idx,
   output logic [CTR_W-1:0]  pred_ctr,
   output logic              pred_taken,
   input  logic              upd_valid,
   input  logic [PC_W-1:0]   upd_pc,
   input  logic              upd_taken
);
   localparam int N_ENT  = 1 << HIST_W;
   localparam int FLAT_W = N_ENT * CTR_W;

   logic [HIST_W-1:0] hist;
   logic [HIST_W-1:0] upd_idx;
   logic [FLAT_W-1:0] ctr_flat;

   gshr_index #(.PC_W(PC_W), .IDX_LO(IDX_LO), .HIST_W(HIST_W)) u_pidx (
      .pc(pred_pc), .hist(hist), .idx(pred_idx)
   );

   // pre-shift history: register still holds the old value this cycle
   gshr_index #(.PC_W(PC_W), .IDX_LO(IDX_LO), .HIST_W(HIST_W)) u_uidx (
      .pc(upd_pc), .hist(hist), .idx(upd_idx)
   );

   gshr_history #(.HIST_W(HIST_W)) u_hist (
      .clk(clk), .rst_n(rst_n), .shift_en(upd_valid),
      .outcome(upd_taken), .hist(hist)
   );

   gshr_ctr_table #(.IDX_W(HIST_W), .CTR_W(CTR_W), .CTR_INIT(CTR_INIT)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(pred_idx), .rd_ctr(pred_ctr),
      .wr_en(upd_valid), .wr_idx(upd_idx), .wr_up(upd_taken),
      .ctr_flat(ctr_flat)
   );

   assign pred_taken = pred_ctr[CTR_W-1];
endmodule

// File: rtl/gshr_predictor_chk.sv
module gshr_predictor_chk #(
   parameter int PC_W   = 16,
   parameter int IDX_LO = 4,
   parameter int HIST_W = 3,
   parameter int CTR_W  = 2,
   parameter int CTR_INIT = 1
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [PC_W-1:0]               pred_pc,
   input logic [CTR_W-1:0]              pred_ctr,
   input logic                          upd_valid,
   input logic [PC_W-1:0]               upd_pc,
   input logic                          upd_taken,
   input logic [HIST_W-1:0]             hist,
   input logic [(1<<HIST_W)*CTR_W-1:0]  ctr_flat
);
   localparam int CMAX = (1 << CTR_W) - 1;

   logic [HIST_W-1:0] chk_uidx;
   logic [CTR_W-1:0]  cur_at_u;
   assign chk_uidx = upd_pc[IDX_LO +: HIST_W] ^ hist;
   assign cur_at_u = ctr_flat[chk_uidx*CTR_W +: CTR_W];

   function automatic logic [CTR_W-1:0] pick(logic [(1<<HIST_W)*CTR_W-1:0] f,
                                              logic [HIST_W-1:0] i);
      return f[i*CTR_W +: CTR_W];
   endfunction

   // R3: taken outcome raises the pre-shift-indexed counter, capped at max
   p_sat_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |=>
         pick(ctr_flat, $past(chk_uidx)) ==
         (($past(cur_at_u) == CTR_W'(CMAX)) ? CTR_W'(CMAX) : $past(cur_at_u) + 1'b1));

   // R4: not-taken outcome lowers the counter, floored at zero
   p_sat_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken) |=>
         pick(ctr_flat, $past(chk_uidx)) ==
         (($past(cur_at_u) == '0) ? '0 : $past(cur_at_u) - 1'b1));

   // R5: history shift with outcome entering at bit 0
   p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> hist == {$past(hist[HIST_W-2:0]), $past(upd_taken)});

   // R8: no valid strobe, no state change
   p_hold_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> ($stable(hist) && $stable(ctr_flat)));

   // R8: with state held, an unchanged lookup PC gives an unchanged counter
   p_hold_pred_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> ($stable(pred_pc) -> $stable(pred_ctr)));

   // R7: history cleared while reset is applied
   p_reset_hist_r7: assert property (@(posedge clk)
      !rst_n |=> (hist == '0 && pred_ctr == CTR_W'(CTR_INIT)));
endmodule

bind gshr_predictor gshr_predictor_chk #(
   .PC_W(PC_W), .IDX_LO(IDX_LO), .HIST_W(HIST_W), .CTR_W(CTR_W), .CTR_INIT(CTR_INIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_ctr(pred_ctr),
   .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
   .hist(hist), .ctr_flat(ctr_flat)
);

// File: tb/gshr_predictor_bench.sv
module gshr_predictor_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pred_pc = '0;
   logic [2:0]  pred_idx;
   logic [1:0]  pred_ctr;
   logic        pred_taken;
   logic        upd_valid = 1'b0;
   logic [15:0] upd_pc = '0;
   logic        upd_taken = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // reference model
   logic [2:0] m_hist;
   logic [1:0] m_ctr [8];

   // scoreboard
   logic [5:0] exp_q [$];
   string      tag_q [$];
   event       sample_ev;

   always #(CLK_PERIOD/2) clk = ~clk;

   gshr_predictor u_gshr_predictor (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_idx(pred_idx),
      .pred_ctr(pred_ctr), .pred_taken(pred_taken), .upd_valid(upd_valid),
      .upd_pc(upd_pc), .upd_taken(upd_taken)
   );

   function automatic logic [2:0] m_index(logic [15:0] pc);
      return pc[6:4] ^ m_hist;
   endfunction

   task automatic check_raw(string tag, logic [5:0] exp);
      checks++;
      if ({pred_idx, pred_ctr, pred_taken} !== exp) begin
         failures++;
         $display("FAIL %s: idx/ctr/taken actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                  tag, pred_idx, pred_ctr, pred_taken, exp[5:3], exp[2:1], exp[0]);
      end
   endtask

   // monitor: pops expected items as results are sampled
   initial begin
      forever begin
         @(sample_ev);
         while (exp_q.size() > 0) check_raw(tag_q.pop_front(), exp_q.pop_front());
      end
   end

   // driver: present a lookup PC, push expectation, trigger sampling
   task automatic look(logic [15:0] pc, string tag);
      logic [2:0] i;
      @(negedge clk);
      pred_pc = pc;
      #1;
      i = m_index(pc);
      exp_q.push_back({i, m_ctr[i], m_ctr[i][1]});
      tag_q.push_back(tag);
      ->sample_ev;
      #1;
   endtask

   task automatic update(logic [15:0] pc, logic t);
      logic [2:0] i;
      @(negedge clk);
      upd_valid = 1'b1; upd_pc = pc; upd_taken = t;
      @(posedge clk);
      i = m_index(pc);                       // R6: pre-shift history
      if (t) m_ctr[i] = (m_ctr[i] == 2'd3) ? 2'd3 : m_ctr[i] + 2'd1;   // R3
      else   m_ctr[i] = (m_ctr[i] == 2'd0) ? 2'd0 : m_ctr[i] - 2'd1;   // R4
      m_hist = {m_hist[1:0], t};             // R5
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      m_hist = '0;
      for (int k = 0; k < 8; k++) m_ctr[k] = 2'd1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R7 and R1: reset state over every PC field value
      for (int k = 0; k < 8; k++) look(16'(k << 4) | 16'h0a03, "R7/R1 reset lookup");

      // R5, R6: two taken outcomes give history 0b011
      update(16'h0000, 1'b1);
      look(16'h0000, "R5 history after one taken");
      update(16'h0000, 1'b1);
      look(16'h0010, "R6 trained entry via pre-shift index");

      // R9: other PC bits ignored; known index values
      look(16'h0100, "R9 pc 0x0100 with history 011");
      check_raw("R9 pc 0x0100 index", {3'd3, m_ctr[3], m_ctr[3][1]});
      look(16'h2454, "R9 pc 0x2454 with history 011");
      check_raw("R9 pc 0x2454 index", {3'd6, m_ctr[6], m_ctr[6][1]});
      look(16'hff84, "R9 high bits ignored");

      // R3: saturate one counter upward (history -> 111, pc field 0 -> entry 7)
      for (int k = 0; k < 6; k++) update(16'h8000, 1'b1);
      look(16'h8000, "R3 saturate at 3");
      check_raw("R3 counter at max", {3'd7, 2'd3, 1'b1});
      // R2: taken flag from counter msb
      look(16'h0070, "R2 taken flag lookup");

      // R4: saturate downward (history -> 000, pc field 5 -> entry 5)
      for (int k = 0; k < 6; k++) update(16'h0050, 1'b0);
      look(16'h0050, "R4 saturate at 0");
      check_raw("R4 counter at min", {3'd5, 2'd0, 1'b0});

      // R8: toggling update inputs without valid changes nothing
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         upd_pc = 16'(k * 16'h0130);
         upd_taken = k[0];
      end
      for (int k = 0; k < 8; k++) look(16'(k << 4), "R8 no update without valid");

      // mixed pattern against reference model (R1..R6)
      lfsr = 16'hace1;
      for (int k = 0; k < 40; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         update(lfsr, lfsr[3] | lfsr[9]);
         look(lfsr, "R6 mixed pattern same pc");
         look(lfsr ^ 16'h0020, "R1 mixed pattern other pc");
      end

      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule